// File: doc/BRIEF.md
# Packed Halving Add/Subtract Unit

This unit operates on two packed integer vectors, 64 or 128 bits wide. In each lane it forms either the sum or the difference of the two operand elements and halves the result. The quotient is truncated: it rounds toward negative infinity for signed lanes and down for unsigned lanes. Each lane is 8, 16 or 32 bits wide, and signed and unsigned lanes share one datapath. Every lane is computed one bit wider than its element, so the sum or difference before halving can never overflow.

A small decoder sits in front of the datapath. It reads the control fields of an instruction: operation bit, signedness bit, two-bit lane-size code, vector-width bit, and three register indices. Each register index has a 4-bit field and one extension bit. The decoder flags any encoding that is reserved or illegal.

The result is registered and appears one cycle after `in_valid`. For an illegal encoding the result still comes out with `out_valid`, but the write enable stays low, so no destination is ever updated.

Top module: `vec_half_arith`

## Requirements
- R1: With `ctl_sub`=0, each result lane equals (a + b) >> 1, computed at lane width plus one bit and truncated to the lane width.
- R2: With `ctl_sub`=1, each result lane equals (a − b) >> 1, truncated. There is no rounding.
- R3: `ctl_uns`=0 selects signed lanes. Operands are sign-extended and the shift is arithmetic, so the result floors toward negative infinity. For example, 0x00 − 0x01 in 8-bit lanes gives 0xFF.
- R4: `ctl_uns`=1 selects unsigned lanes. Operands are zero-extended and the shift is logical. For example, 0xFF + 0xFF gives 0xFF, and 0xFF + 0x01 gives 0x80.
- R5: `ctl_size` codes 0, 1 and 2 select 8-, 16- and 32-bit lanes. No carry or borrow crosses a lane boundary.
- R6: `ctl_size`=3 is reserved and raises `out_undef`.
- R7: With `ctl_wide`=1, an odd 4-bit index field (bit 0 set in `idx_dst`, `idx_a` or `idx_b`) raises `out_undef`. With `ctl_wide`=0, odd indices are legal.
- R8: With `ctl_wide`=0, only operand bits 63:0 are used and `out_res[127:64]` is zero. Upper operand bits have no effect.
- R9: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high.
- R10: When `out_undef` is high, `out_valid` is high, `out_we` is low and `out_res` is zero. For a legal encoding, `out_we` follows `out_valid`.
- R11: `out_dst`, `out_src_a` and `out_src_b` each equal {extension bit, 4-bit field} of their index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request |
| ctl_sub | input | 1 | 0 = halving add, 1 = halving subtract |
| ctl_uns | input | 1 | 1 = unsigned lanes, 0 = signed lanes |
| ctl_size | input | 2 | Lane size code: 0 = 8, 1 = 16, 2 = 32 bits, 3 = reserved |
| ctl_wide | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| idx_dst_hi | input | 1 | Destination index extension bit |
| idx_dst | input | 4 | Destination index field |
| idx_a_hi | input | 1 | First source index extension bit |
| idx_a | input | 4 | First source index field |
| idx_b_hi | input | 1 | Second source index extension bit |
| idx_b | input | 4 | Second source index field |
| opa | input | 128 | First operand vector |
| opb | input | 128 | Second operand vector |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_we | output | 1 | Destination write enable |
| out_undef | output | 1 | Illegal encoding flag |
| out_dst | output | 5 | Destination register index |
| out_src_a | output | 5 | First source register index |
| out_src_b | output | 5 | Second source register index |
| out_res | output | 128 | Packed result |

## Verification
The clocked properties assume that control fields are sampled only in cycles where `in_valid` is high, and that reset is applied before the first request. The stimulus drives all inputs on the falling edge and holds them stable through the next rising edge. Between requests it returns `in_valid` low, so that idle cycles can be observed. Operand values reach the extreme values of each lane, and they are checked against a lane model built from the requirements at every size and signedness.

// File: rtl/vha_pkg.sv
package vha_pkg;
    localparam int VEC_W  = 128;
    localparam int HALF_W = VEC_W / 2;
    localparam int FLD_W  = 4;
    localparam int IDX_W  = FLD_W + 1;
    localparam int N_SZ   = 3;

    typedef enum logic [1:0] {
        SZ_B   = 2'd0,
        SZ_H   = 2'd1,
        SZ_W   = 2'd2,
        SZ_RSV = 2'd3
    } lane_sz_e;

    typedef struct packed {
        logic             sub;
        logic             uns;
        lane_sz_e         size;
        logic             wide;
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] src_a;
        logic [IDX_W-1:0] src_b;
        logic             undef;
    } dec_t;

    function automatic logic [IDX_W-1:0] join_idx(input logic hi, input logic [FLD_W-1:0] fld);
        return {hi, fld};
    endfunction
endpackage

// File: rtl/vha_decode.sv
module vha_decode
    import vha_pkg::*;
(
    input  logic             sub,
    input  logic             uns,
    input  logic [1:0]       size,
    input  logic             wide,
    input  logic             d_hi,
    input  logic [FLD_W-1:0] d_fld,
    input  logic             a_hi,
    input  logic [FLD_W-1:0] a_fld,
    input  logic             b_hi,
    input  logic [FLD_W-1:0] b_fld,
    output dec_t             dec
);
    logic odd_idx;

    always_comb begin
        odd_idx    = d_fld[0] | a_fld[0] | b_fld[0];
        dec.sub    = sub;
        dec.uns    = uns;
        dec.size   = lane_sz_e'(size);
        dec.wide   = wide;
        dec.dst    = join_idx(d_hi, d_fld);
        dec.src_a  = join_idx(a_hi, a_fld);
        dec.src_b  = join_idx(b_hi, b_fld);
        dec.undef  = (lane_sz_e'(size) == SZ_RSV) | (wide & odd_idx);
    end
endmodule

// File: rtl/vha_lane.sv
module vha_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         uns,
    output logic [W-1:0] y
);
    logic [W:0] ea, eb, wide_sum;

    always_comb begin
        ea       = {~uns & a[W-1], a};
        eb       = {~uns & b[W-1], b};
        wide_sum = sub ? (ea - eb) : (ea + eb);
        y        = wide_sum[W:1];
    end
endmodule

// File: rtl/vha_datapath.sv
module vha_datapath
    import vha_pkg::*;
(
    input  logic [VEC_W-1:0] opa,
    input  logic [VEC_W-1:0] opb,
    input  dec_t             dec,
    output logic [VEC_W-1:0] res
);
    logic [N_SZ-1:0][VEC_W-1:0] res_sz;
    logic [VEC_W-1:0]           picked;

    for (genvar k = 0; k < N_SZ; k++) begin : g_sz
        localparam int LW = 8 << k;
        localparam int NL = VEC_W / LW;
        for (genvar i = 0; i < NL; i++) begin : g_ln
            vha_lane #(.W(LW)) u_lane (
                .a   (opa[i*LW +: LW]),
                .b   (opb[i*LW +: LW]),
                .sub (dec.sub),
                .uns (dec.uns),
                .y   (res_sz[k][i*LW +: LW])
            );
        end
    end

    always_comb begin
        case (dec.size)
            SZ_B:    picked = res_sz[0];
            SZ_H:    picked = res_sz[1];
            SZ_W:    picked = res_sz[2];
            default: picked = '0;
        endcase
        res = dec.wide ? picked : {{HALF_W{1'b0}}, picked[HALF_W-1:0]};
    end
endmodule

// File: rtl/vec_half_arith.sv
module vec_half_arith
    import vha_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              ctl_sub,
    input  logic              ctl_uns,
    input  logic [1:0]        ctl_size,
    input  logic              ctl_wide,
    input  logic              idx_dst_hi,
    input  logic [3:0]        idx_dst,
    input  logic              idx_a_hi,
    input  logic [3:0]        idx_a,
    input  logic              idx_b_hi,
    input  logic [3:0]        idx_b,
    input  logic [127:0]      opa,
    input  logic [127:0]      opb,
    output logic              out_valid,
    output logic              out_we,
    output logic              out_undef,
    output logic [4:0]        out_dst,
    output logic [4:0]        out_src_a,
    output logic [4:0]        out_src_b,
    output logic [127:0]      out_res
);
    dec_t             dec;
    logic [VEC_W-1:0] dp_res;
    logic             wide_q;

    vha_decode u_dec (
        .sub   (ctl_sub),
        .uns   (ctl_uns),
        .size  (ctl_size),
        .wide  (ctl_wide),
        .d_hi  (idx_dst_hi),
        .d_fld (idx_dst),
        .a_hi  (idx_a_hi),
        .a_fld (idx_a),
        .b_hi  (idx_b_hi),
        .b_fld (idx_b),
        .dec   (dec)
    );

    vha_datapath u_dp (
        .opa (opa),
        .opb (opb),
        .dec (dec),
        .res (dp_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_we    <= 1'b0;
            out_undef <= 1'b0;
            out_dst   <= '0;
            out_src_a <= '0;
            out_src_b <= '0;
            out_res   <= '0;
            wide_q    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_we    <= in_valid & ~dec.undef;
            out_undef <= in_valid & dec.undef;
            if (in_valid) begin
                out_dst   <= dec.dst;
                out_src_a <= dec.src_a;
                out_src_b <= dec.src_b;
                out_res   <= dec.undef ? '0 : dp_res;
                wide_q    <= dec.wide;
            end
        end
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R9
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R9
    AST_UNDEF_BLOCKS_WE: assert property (@(posedge clk) disable iff (rst)
        out_undef |-> (out_valid && !out_we && out_res == '0)); // R10
    AST_RSV_SIZE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctl_size == 2'b11) |=> out_undef); // R6
    AST_ODD_WIDE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctl_wide && (idx_a[0] || idx_b[0] || idx_dst[0])) |=> out_undef); // R7
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !wide_q) |-> out_res[127:64] == '0); // R8
endmodule

// File: tb/sim_vec_half_arith.sv
module sim_vec_half_arith;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         ctl_sub = 1'b0, ctl_uns = 1'b0, ctl_wide = 1'b0;
    logic [1:0]   ctl_size = 2'd0;
    logic         idx_dst_hi = 1'b0, idx_a_hi = 1'b0, idx_b_hi = 1'b0;
    logic [3:0]   idx_dst = 4'd0, idx_a = 4'd0, idx_b = 4'd0;
    logic [127:0] opa = '0, opb = '0;
    logic         out_valid, out_we, out_undef;
    logic [4:0]   out_dst, out_src_a, out_src_b;
    logic [127:0] out_res;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    vec_half_arith u0 (.*);

    function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                           input int sz, input logic sub, input logic uns,
                                           input logic wide);
        logic [127:0] r = '0;
        int w  = 8 << sz;
        int nl = (wide ? 128 : 64) / w;
        for (int i = 0; i < nl; i++) begin
            longint ea = 0, eb = 0, s;
            for (int j = 0; j < w; j++) begin
                ea[j] = a[i*w + j];
                eb[j] = b[i*w + j];
            end
            if (!uns && ea[w-1]) ea = ea - (longint'(1) << w);
            if (!uns && eb[w-1]) eb = eb - (longint'(1) << w);
            s = sub ? ea - eb : ea + eb;
            s = s >>> 1;
            for (int j = 0; j < w; j++) r[i*w + j] = s[j];
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [127:0] a, input logic [127:0] b, input int sz,
                         input logic sub, input logic uns, input logic wide,
                         input logic [4:0] d, input logic [4:0] sa, input logic [4:0] sb);
        @(negedge clk);
        opa = a; opb = b; ctl_size = sz[1:0]; ctl_sub = sub; ctl_uns = uns; ctl_wide = wide;
        {idx_dst_hi, idx_dst} = d; {idx_a_hi, idx_a} = sa; {idx_b_hi, idx_b} = sb;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_legal(input string tag, input logic [127:0] a, input logic [127:0] b,
                             input int sz, input logic sub, input logic uns, input logic wide);
        logic [127:0] exp;
        exp = model(a, b, sz, sub, uns, wide);
        issue(a, b, sz, sub, uns, wide, 5'd2, 5'd4, 5'd6);
        check(out_res == exp, tag, out_res, exp);
        check(out_valid && out_we && !out_undef, {tag, " R10 we"},
              {125'd0, out_valid, out_we, out_undef}, 128'h6);
    endtask

    task automatic t_reset();
        check(!out_valid && !out_we && out_res == '0, "R9 reset state", out_res, '0);
    endtask

    task automatic t_hand_values();
        issue({16{8'hFF}}, {16{8'h01}}, 0, 1'b0, 1'b1, 1'b1, 5'd0, 5'd2, 5'd4);
        check(out_res == {16{8'h80}}, "R4 R1 unsigned FF+01", out_res, {16{8'h80}});
        issue({16{8'hFF}}, {16{8'hFF}}, 0, 1'b0, 1'b1, 1'b1, 5'd0, 5'd2, 5'd4);
        check(out_res == {16{8'hFF}}, "R4 unsigned FF+FF", out_res, {16{8'hFF}});
        issue({16{8'hFF}}, {16{8'h01}}, 0, 1'b0, 1'b0, 1'b1, 5'd0, 5'd2, 5'd4);
        check(out_res == '0, "R3 signed -1+1", out_res, '0);
        issue({16{8'h00}}, {16{8'h01}}, 0, 1'b1, 1'b0, 1'b1, 5'd0, 5'd2, 5'd4);
        check(out_res == {16{8'hFF}}, "R3 R2 signed 0-1 floors", out_res, {16{8'hFF}});
        issue({8{16'h0005}}, {8{16'h0002}}, 1, 1'b1, 1'b1, 1'b1, 5'd0, 5'd2, 5'd4);
        check(out_res == {8{16'h0001}}, "R2 halfword 5-2", out_res, {8{16'h0001}});
        issue({4{32'hFFFFFFFF}}, {4{32'h00000001}}, 2, 1'b0, 1'b1, 1'b1, 5'd0, 5'd2, 5'd4);
        check(out_res == {4{32'h80000000}}, "R5 word lane carry isolated", out_res,
              {4{32'h80000000}});
    endtask

    task automatic t_model_sweep();
        logic [127:0] a = 128'h80FF_7F01_8000_7FFF_0123_4567_89AB_CDEF;
        logic [127:0] b = 128'h7F01_80FF_FFFF_8000_FEDC_BA98_7654_3210;
        for (int sz = 0; sz < 3; sz++)
            for (int m = 0; m < 4; m++)
                run_legal($sformatf("R1 R2 R3 R4 R5 sz=%0d mode=%0d", sz, m),
                          a, b, sz, m[0], m[1], 1'b1);
    endtask

    task automatic t_reserved_size();
        issue({16{8'h11}}, {16{8'h22}}, 3, 1'b0, 1'b0, 1'b1, 5'd0, 5'd2, 5'd4);
        check(out_valid && out_undef && !out_we, "R6 size 3 undefined",
              {125'd0, out_valid, out_undef, out_we}, 128'h6);
        check(out_res == '0, "R10 undefined result zero", out_res, '0);
    endtask

    task automatic t_odd_index();
        issue({16{8'h11}}, {16{8'h22}}, 0, 1'b0, 1'b0, 1'b1, 5'd0, 5'd2, 5'd5);
        check(out_undef && !out_we && out_valid, "R7 wide odd index undefined",
              {125'd0, out_valid, out_undef, out_we}, 128'h6);
        issue({16{8'h10}}, {16{8'h20}}, 0, 1'b0, 1'b0, 1'b0, 5'd1, 5'd3, 5'd5);
        check(!out_undef && out_we, "R7 narrow odd index legal",
              {126'd0, out_undef, out_we}, 128'h1);
        check(out_res == {64'd0, {8{8'h18}}}, "R7 narrow odd result", out_res,
              {64'd0, {8{8'h18}}});
    endtask

    task automatic t_narrow_upper();
        logic [127:0] a = {64'hDEAD_BEEF_CAFE_F00D, 64'h0102_0304_0506_0708};
        logic [127:0] b = {64'h1234_5678_9ABC_DEF0, 64'h0808_0808_0808_0808};
        logic [127:0] exp = {64'd0, model(a, b, 1, 1'b0, 1'b1, 1'b0)};
        issue(a, b, 1, 1'b0, 1'b1, 1'b0, 5'd0, 5'd2, 5'd4);
        check(out_res == exp, "R8 narrow upper zero", out_res, exp);
    endtask

    task automatic t_latency_and_fields();
        issue({16{8'h02}}, {16{8'h04}}, 0, 1'b0, 1'b1, 1'b1, 5'b1_0110, 5'b0_1010, 5'b1_1100);
        check(out_valid, "R9 valid after request", {127'd0, out_valid}, 128'h1);
        check(out_dst == 5'b1_0110, "R11 dst index", {123'd0, out_dst}, 128'h16);
        check(out_src_a == 5'b0_1010 && out_src_b == 5'b1_1100, "R11 src indices",
              {118'd0, out_src_a, out_src_b}, {118'd0, 5'b0_1010, 5'b1_1100});
        @(negedge clk);
        check(!out_valid && !out_we, "R9 valid single pulse",
              {126'd0, out_valid, out_we}, 128'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_hand_values();
        t_model_sweep();
        t_reserved_size();
        t_odd_index();
        t_narrow_upper();
        t_latency_and_fields();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule